// File: doc/BRIEF.md
# Microwire Serial EEPROM Command Master

This block sits on the host side of a three-wire-plus-select serial EEPROM link and turns single-word command requests into correctly framed serial transactions. A requester presents an operation (read, write, write-enable or write-disable), a word address and 16-bit write data on a valid/ready handshake. The block generates chip select, the serial clock and the serial data output, samples the serial data input, and finishes each command with a one-cycle done strobe carrying the read word and an error flag.

The serial clock is derived from the system clock by a programmable divider: each low or high phase lasts `div_cfg + 1` system cycles. A configuration input selects 6-bit or 8-bit word addressing, which changes the length of every command frame. Reads clock in one extra bit so that the memory's leading zero falls away. Writes are followed by a busy poll that waits for the memory to signal ready, bounded by a timeout.

The control is one state machine. Its states are IDLE (waiting for a request), SELECT (chip select high for one serial clock pulse with data out low), SHIFT_OUT (start bit, opcode, address and any write data), SHIFT_IN (17 input bits for a read), GAP (chip select low for one serial clock period after write data), POLL (chip select high, pulses until data in is seen high, or timeout) and PARK (chip select low for one full pulse). Transitions: IDLE→SELECT on an accepted request; SELECT→SHIFT_OUT after its pulse; SHIFT_OUT→SHIFT_IN for a read, →GAP for a write, →PARK for enable/disable, each after the last frame bit; SHIFT_IN→PARK after the 17th bit; GAP→POLL after one period; POLL→PARK on ready or on timeout; PARK→IDLE after its pulse, raising done.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: While idle (after reset and between commands) `req_ready` is 1 and `mw_cs`, `mw_sk` and `mw_dout` are all 0; a request is accepted only while `req_ready` is 1, and `req_ready` is 0 from the accept until the done strobe.
- R2: Every low and every high phase of `mw_sk` lasts exactly `div_cfg + 1` system clock cycles, so one serial clock period is `2*(div_cfg+1)` cycles; `mw_sk` rises only on a divider tick.
- R3: A command begins with chip select raised while `mw_sk` is low and one serial pulse with `mw_dout` at 0, followed by a start bit of 1, a 2-bit wire opcode (read 10, write 01, enable and disable 00) and the address MSB first; `mw_dout` changes only while `mw_sk` is low and the input is sampled at the rising edge.
- R4: With `cfg_wide` = 1 the address field is 8 bits (`req_addr[7:0]`); with `cfg_wide` = 0 it is 6 bits (`req_addr[5:0]`) and `req_addr[7:6]` has no effect.
- R5: `req_op` encoding: 0 read, 1 write, 2 write-enable, 3 write-disable. Enable sends an address field whose two top bits are 11 and disable sends 00, all other address bits 0, for a frame of 9 bits (6-bit addressing) or 11 bits (8-bit addressing) including the start bit.
- R6: A read clocks in 17 input bits after the address and returns the last 16 on `rsp_rdata`, first received bit as MSB, dropping the leading zero.
- R7: A write sends the 16 bits of `req_wdata` MSB first directly after the address.
- R8: After write data, chip select is held low for one serial clock period, raised again, and serial pulses continue until `mw_din` is sampled 1 at a rising edge.
- R9: If `POLL_LIMIT` system cycles pass in the poll without ready, the poll ends and the done strobe carries `rsp_err` = 1; `rsp_err` is 0 on every other done strobe.
- R10: Every command ends with chip select low and one full serial pulse, then a single-cycle `rsp_done`, at which point the block is idle again.
- R11: A read completes with `rsp_done` high exactly `2*(22+AW)*(div_cfg+1)` cycles after the accepting clock edge, AW being 6 or 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1 selects 8-bit addressing, 0 selects 6-bit |
| div_cfg | input | DIV_W | Serial clock phase length minus one, in system cycles |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 enable, 3 disable |
| req_addr | input | ADDR_W_WIDE | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | DATA_W | Read word, valid with `rsp_done` after a read |
| rsp_err | output | 1 | Poll timeout, valid with `rsp_done` |
| mw_cs | output | 1 | Chip select to the memory |
| mw_sk | output | 1 | Serial clock to the memory |
| mw_dout | output | 1 | Serial data to the memory |
| mw_din | input | 1 | Serial data from the memory |

## Verification
A read's done strobe is due exactly `2*(22+AW)*(div_cfg+1)` cycles after the accepting edge, and the bench counts cycles from that edge to the first falling-edge sample where `rsp_done` is high, comparing against the formula for both address widths and two divider values. Write and enable completions depend on how long the memory model holds busy, so their results are checked by the scoreboard when the strobe appears rather than at a fixed cycle, while a bus-level model records frame lengths and poll pulse counts at each chip-select fall. All outputs are sampled on the falling system clock edge, half a cycle away from the edge that changes them.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_WREN  = 2'd2,
        OP_WRDIS = 2'd3
    } uw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_SHIFT_OUT,
        ST_SHIFT_IN,
        ST_GAP,
        ST_POLL,
        ST_PARK
    } uw_state_e;

endpackage

// File: rtl/uwire_tick.sv
module uwire_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = !clr && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uwire_poll_timer.sv
module uwire_poll_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] elapsed;

    assign expired = run && (elapsed == TW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            elapsed <= '0;
        else if (!run)
            elapsed <= '0;
        else if (!expired)
            elapsed <= elapsed + 1'b1;
    end
endmodule

// File: rtl/uwire_frame.sv
module uwire_frame
    import uwire_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W_NARR = 6,
    parameter int ADDR_W_WIDE = 8,
    parameter int FRAME_W     = 3 + ADDR_W_WIDE + DATA_W,
    parameter int CNT_W       = $clog2(FRAME_W + 1)
) (
    input  uw_op_e                 op,
    input  logic                   wide,
    input  logic [ADDR_W_WIDE-1:0] addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [FRAME_W-1:0]     frame,
    output logic [CNT_W-1:0]       len
);
    localparam int PAD_W = ADDR_W_WIDE - ADDR_W_NARR;

    logic [1:0]             opc;
    logic [ADDR_W_WIDE-1:0] afield;

    always_comb begin
        unique case (op)
            OP_READ:  opc = 2'b10;
            OP_WRITE: opc = 2'b01;
            default:  opc = 2'b00;
        endcase

        // address held left-justified so the special codes sit in the top bits
        if (op == OP_WREN)
            afield = {2'b11, {(ADDR_W_WIDE-2){1'b0}}};
        else if (op == OP_WRDIS)
            afield = '0;
        else if (wide)
            afield = addr;
        else
            afield = {addr[ADDR_W_NARR-1:0], {PAD_W{1'b0}}};

        if (wide)
            frame = {1'b1, opc, afield, wdata};
        else
            frame = {1'b1, opc, afield[ADDR_W_WIDE-1 -: ADDR_W_NARR], wdata, {PAD_W{1'b0}}};

        len = CNT_W'(3)
            + (wide ? CNT_W'(ADDR_W_WIDE) : CNT_W'(ADDR_W_NARR))
            + ((op == OP_WRITE) ? CNT_W'(DATA_W) : CNT_W'(0));
    end
endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
    import uwire_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W_NARR = 6,
    parameter int ADDR_W_WIDE = 8,
    parameter int DIV_W       = 8,
    parameter int POLL_LIMIT  = 4096
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wide,
    input  logic [DIV_W-1:0]       div_cfg,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [1:0]             req_op,
    input  logic [ADDR_W_WIDE-1:0] req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_done,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   rsp_err,
    output logic                   mw_cs,
    output logic                   mw_sk,
    output logic                   mw_dout,
    input  logic                   mw_din
);
    localparam int FRAME_W = 3 + ADDR_W_WIDE + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int RD_BITS = DATA_W + 1;

    uw_state_e              state, nxt;
    uw_op_e                 op_q;
    logic                   hi;
    logic                   sk_q;
    logic [FRAME_W-1:0]     shreg;
    logic [CNT_W-1:0]       bits_left;
    logic [DATA_W-1:0]      rd_sh;
    logic                   rdy_seen;
    logic                   done_q;
    logic                   err_q;
    logic                   div_tick;
    logic                   poll_expired;
    logic [FRAME_W-1:0]     frame_w;
    logic [CNT_W-1:0]       len_w;
    logic                   fall;

    uwire_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_IDLE || poll_expired),
        .div   (div_cfg),
        .tick  (div_tick)
    );

    uwire_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_POLL),
        .expired (poll_expired)
    );

    uwire_frame #(
        .DATA_W      (DATA_W),
        .ADDR_W_NARR (ADDR_W_NARR),
        .ADDR_W_WIDE (ADDR_W_WIDE),
        .FRAME_W     (FRAME_W),
        .CNT_W       (CNT_W)
    ) u_frame (
        .op    (uw_op_e'(req_op)),
        .wide  (cfg_wide),
        .addr  (req_addr),
        .wdata (req_wdata),
        .frame (frame_w),
        .len   (len_w)
    );

    assign fall = div_tick && hi;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (req_valid) nxt = ST_SELECT;
            ST_SELECT:    if (fall) nxt = ST_SHIFT_OUT;
            ST_SHIFT_OUT: if (fall && bits_left == CNT_W'(1)) begin
                              if (op_q == OP_READ)       nxt = ST_SHIFT_IN;
                              else if (op_q == OP_WRITE) nxt = ST_GAP;
                              else                       nxt = ST_PARK;
                          end
            ST_SHIFT_IN:  if (fall && bits_left == CNT_W'(1)) nxt = ST_PARK;
            ST_GAP:       if (fall) nxt = ST_POLL;
            ST_POLL:      if (poll_expired || (fall && rdy_seen)) nxt = ST_PARK;
            ST_PARK:      if (fall) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath: serial phase, shifters, response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_READ;
            hi        <= 1'b0;
            sk_q      <= 1'b0;
            shreg     <= '0;
            bits_left <= '0;
            rd_sh     <= '0;
            rdy_seen  <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state == ST_IDLE) begin
                hi   <= 1'b0;
                sk_q <= 1'b0;
                if (req_valid) begin
                    shreg     <= frame_w;
                    bits_left <= len_w;
                    op_q      <= uw_op_e'(req_op);
                    err_q     <= 1'b0;
                end
            end else if (poll_expired) begin
                hi    <= 1'b0;
                sk_q  <= 1'b0;
                err_q <= 1'b1;
            end else if (div_tick) begin
                hi <= !hi;
                if (!hi) begin
                    // rising phase boundary: sample input here
                    if (state != ST_GAP) sk_q <= 1'b1;
                    if (state == ST_SHIFT_IN) rd_sh <= {rd_sh[DATA_W-2:0], mw_din};
                    if (state == ST_POLL) rdy_seen <= mw_din;
                end else begin
                    sk_q <= 1'b0;
                    unique case (state)
                        ST_SHIFT_OUT: begin
                            shreg <= {shreg[FRAME_W-2:0], 1'b0};
                            if (bits_left == CNT_W'(1)) bits_left <= CNT_W'(RD_BITS);
                            else                        bits_left <= bits_left - 1'b1;
                        end
                        ST_SHIFT_IN: bits_left <= bits_left - 1'b1;
                        ST_GAP:      rdy_seen <= 1'b0;
                        ST_PARK:     done_q <= 1'b1;
                        default:     ;
                    endcase
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        mw_sk     = sk_q;
        mw_cs     = (state == ST_SELECT) || (state == ST_SHIFT_OUT) ||
                    (state == ST_SHIFT_IN) || (state == ST_POLL);
        mw_dout   = (state == ST_SHIFT_OUT) ? shreg[FRAME_W-1] : 1'b0;
        rsp_done  = done_q;
        rsp_err   = done_q && err_q;
        rsp_rdata = rd_sh;
    end
endmodule

// File: rtl/uwire_eeprom_ctrl_chk.sv
module uwire_eeprom_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic mw_cs,
    input logic mw_sk,
    input logic mw_dout,
    input logic rsp_done,
    input logic rsp_err,
    input logic tick
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mw_cs && !mw_sk && !mw_dout));

    // R2
    sk_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mw_sk) |-> $past(tick));

    // R3
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mw_sk |-> $stable(mw_dout));

    // R3
    cs_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mw_cs) |-> !mw_sk);

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (req_ready && !mw_cs && !mw_sk));
endmodule

bind uwire_eeprom_ctrl uwire_eeprom_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mw_cs     (mw_cs),
    .mw_sk     (mw_sk),
    .mw_dout   (mw_dout),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .tick      (div_tick)
);

// File: tb/uwire_eeprom_ctrl_test.sv
module uwire_eeprom_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY_RISES = 3;
    localparam int POLL_LIM   = 300;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_wide = 0;
    logic [7:0]  div_cfg = 8'd1;
    logic        req_valid = 0;
    logic        req_ready;
    logic [1:0]  req_op = 0;
    logic [7:0]  req_addr = 0;
    logic [15:0] req_wdata = 0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        rsp_err;
    logic        mw_cs, mw_sk, mw_dout;
    logic        mw_din = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    uwire_eeprom_ctrl #(.POLL_LIMIT(POLL_LIM)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .div_cfg(div_cfg),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .mw_cs(mw_cs), .mw_sk(mw_sk),
        .mw_dout(mw_dout), .mw_din(mw_din)
    );

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] seed_word(input int i);
        return 16'hA000 ^ 16'(i * 16'h0137);
    endfunction

    // ---------------- bus-level memory model ----------------
    logic [15:0] m_mem [256];
    bit          m_en = 0;
    int          m_busy = 0;
    bit          m_stuck = 0;
    bit          m_started = 0;
    int          m_len = 0;
    int          m_last_len = 0;
    logic [1:0]  m_op = 0;
    logic [1:0]  m_last_op = 0;
    logic [7:0]  m_addr = 0;
    logic [15:0] m_data = 0;
    logic [15:0] m_rd = 0;
    int          m_poll_rises = 0;
    time         t_prev = 0, t_last = 0;

    function automatic int aw();
        return cfg_wide ? 8 : 6;
    endfunction

    always @(posedge mw_cs) begin
        m_started = 0;
        m_len = 0;
        m_poll_rises = 0;
        mw_din <= (m_busy == 0 && !m_stuck);
    end

    always @(posedge mw_sk) begin
        t_prev = t_last;
        t_last = $time;
        if (mw_cs) begin
            if (!m_started) begin
                m_poll_rises++;
                if (m_busy > 0) m_busy--;
                if (m_busy == 0 && !m_stuck) mw_din <= 1'b1;
                if (mw_dout) begin
                    m_started = 1; m_len = 1; m_op = 0; m_addr = 0; m_data = 0;
                end
            end else begin
                m_len++;
                if (m_len <= 3) m_op = {m_op[0], mw_dout};
                else if (m_len <= 3 + aw()) m_addr = {m_addr[6:0], mw_dout};
                else if (m_op == 2'b01) m_data = {m_data[14:0], mw_dout};
                if (m_op == 2'b10 && m_len == 3 + aw()) begin
                    m_rd = m_mem[m_addr];
                    mw_din <= 1'b0;
                end else if (m_op == 2'b10 && m_len > 3 + aw()) begin
                    mw_din <= m_rd[15];
                    m_rd = {m_rd[14:0], 1'b0};
                end
            end
        end
    end

    always @(negedge mw_cs) begin
        if (m_started) begin
            m_started = 0;
            m_last_len = m_len;
            m_last_op = m_op;
            if (m_op == 2'b01 && m_len == 19 + aw()) begin
                if (m_en) begin
                    m_mem[m_addr] = m_data;
                    m_busy = BUSY_RISES;
                end
            end else if (m_op == 2'b00) begin
                if ((cfg_wide ? m_addr[7:6] : m_addr[5:4]) == 2'b11) m_en = 1;
                else if ((cfg_wide ? m_addr[7:6] : m_addr[5:4]) == 2'b00) m_en = 0;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          chk_data;
        logic [15:0] data;
        bit          err;
        string       tag;
    } sb_item_t;

    sb_item_t    sb_q[$];
    logic [15:0] exp_mem [256];
    bit          exp_en = 0;
    int          acc_cyc = 0;
    int          last_lat = 0;

    always @(negedge clk) begin
        if (rsp_done) begin
            if (sb_q.size() == 0) begin
                chk(0, "R10 unexpected done", 1, 0);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                chk(rsp_err == it.err, {it.tag, " err flag"}, int'(rsp_err), int'(it.err));
                if (it.chk_data)
                    chk(rsp_rdata == it.data, {it.tag, " read word"}, int'(rsp_rdata), int'(it.data));
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic [7:0] addr,
                         input logic [15:0] wd, input bit exp_err, input string tag);
        sb_item_t it;
        logic [7:0] a;
        a = cfg_wide ? addr : {2'b00, addr[5:0]};
        it.chk_data = (op == 2'd0);
        it.data = exp_mem[a];
        it.err = exp_err;
        it.tag = tag;
        if (op == 2'd1 && exp_en) exp_mem[a] = wd;
        if (op == 2'd2) exp_en = 1;
        if (op == 2'd3) exp_en = 0;
        sb_q.push_back(it);
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = addr; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        acc_cyc = cyc;
        chk(req_ready == 1'b0, "R10 busy after accept", int'(req_ready), 0);
        while (!rsp_done) @(negedge clk);
        last_lat = cyc - acc_cyc;
        @(negedge clk);
        // R1 idle after completion
        chk(req_ready && !mw_cs && !mw_sk && !mw_dout, "R1 idle after command",
            int'({req_ready, mw_cs, mw_sk, mw_dout}), 'b1000);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_mem[i] = seed_word(i);
            exp_mem[i] = seed_word(i);
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
        chk({mw_cs, mw_sk, mw_dout, rsp_done} == 4'b0, "R1 bus quiet in reset",
            int'({mw_cs, mw_sk, mw_dout, rsp_done}), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(req_ready && !mw_cs && !mw_sk, "R1 idle after reset", int'(req_ready), 1);

        // narrow addressing, divider 1
        cfg_wide = 0; div_cfg = 8'd1;
        issue(2'd0, 8'h05, 16'h0, 0, "R6 narrow read");
        chk(last_lat == 2*(22+6)*2, "R11 narrow read latency", last_lat, 2*(22+6)*2);
        chk(m_last_len == 26, "R6 read frame bits", m_last_len, 26);
        chk(m_last_op == 2'b10, "R3 read opcode", int'(m_last_op), 2);
        issue(2'd0, 8'hC5, 16'h0, 0, "R4 upper address bits ignored");

        issue(2'd1, 8'h09, 16'h1234, 0, "R5 write while disabled");
        chk(m_poll_rises == 1, "R8 immediate ready poll", m_poll_rises, 1);
        issue(2'd0, 8'h09, 16'h0, 0, "R5 protected word unchanged");

        issue(2'd2, 8'h00, 16'h0, 0, "R5 enable narrow");
        chk(m_last_len == 9, "R5 enable frame length narrow", m_last_len, 9);
        issue(2'd1, 8'h09, 16'hBEEF, 0, "R7 narrow write");
        chk(m_last_len == 25, "R7 write frame bits", m_last_len, 25);
        chk(m_last_op == 2'b01, "R3 write opcode", int'(m_last_op), 1);
        chk(m_poll_rises == BUSY_RISES + 1, "R8 poll until ready", m_poll_rises, BUSY_RISES + 1);
        issue(2'd0, 8'h09, 16'h0, 0, "R7 narrow readback");

        // wide addressing, divider 3
        cfg_wide = 1; div_cfg = 8'd3;
        issue(2'd2, 8'h00, 16'h0, 0, "R5 enable wide");
        chk(m_last_len == 11, "R5 enable frame length wide", m_last_len, 11);
        issue(2'd1, 8'hA7, 16'h5A3C, 0, "R7 wide write");
        chk(m_last_len == 27, "R4 wide write frame bits", m_last_len, 27);
        issue(2'd0, 8'hA7, 16'h0, 0, "R4 wide readback");
        chk(last_lat == 2*(22+8)*4, "R11 wide read latency", last_lat, 2*(22+8)*4);
        chk(t_last - t_prev == time'(2*4*CLK_PERIOD), "R2 serial clock period",
            int'(t_last - t_prev), 2*4*CLK_PERIOD);
        chk(m_last_len == 28, "R6 wide read frame bits", m_last_len, 28);
        issue(2'd0, 8'hC5, 16'h0, 0, "R4 wide address top bits used");

        issue(2'd3, 8'h00, 16'h0, 0, "R5 disable wide");
        chk(m_last_len == 11, "R5 disable frame length", m_last_len, 11);
        issue(2'd1, 8'hA7, 16'hFFFF, 0, "R5 write after disable");
        issue(2'd0, 8'hA7, 16'h0, 0, "R5 disabled write ignored");

        // poll timeout
        issue(2'd2, 8'h00, 16'h0, 0, "R5 enable before timeout");
        m_stuck = 1;
        issue(2'd1, 8'h03, 16'h7E81, 1, "R9 poll timeout error");
        m_stuck = 0;
        m_busy = 0;
        issue(2'd0, 8'h03, 16'h0, 0, "R9 error clears on next command");

        repeat (5) @(negedge clk);
        chk(sb_q.size() == 0, "R10 all commands completed", sb_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R10 actual=0x0 expected=0x1");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule